// File: doc/BRIEF.md
# SPI Register Front-End for a CAN Controller

This block is the host-facing side of a CAN controller that a processor reaches over a four-wire serial link (clock idles low, data sampled on the rising edge, most significant bit first, 8-bit words). Every transaction opens with a one-byte command code. A write command takes one data byte. A read command takes one dummy byte, during which the block returns the selected register. A lone reset command returns the configuration to its initial state.

The block keeps the configuration registers: operating control, transmit control, interrupt enable and the two bit-timing words. It also holds two sticky event registers, for interrupt flags and error flags, and both are cleared by reading them. It assembles a status byte from live condition inputs and passes the message-status and error-counter inputs through to reads. The protocol engine that produces the events and the counters sits outside this block. It drives them in through ports. The block drives the operating mode, the transmit enable and a level interrupt back out.

The serial inputs are asynchronous to the core clock. They pass through synchronizers and are edge-detected in the core clock domain, so the serial clock must run several times slower than the core clock.

Top module: `canspi_frontend`

## Requirements
- R1: Each transaction runs while `spi_cs_n` is low. The first byte is the command. A write sends one data byte next, and a read returns the register value MSB-first in the second byte. Raising `spi_cs_n` part way through a byte ends the transaction and discards that byte.
- R2: Configuration write codes are 0x14 (control), 0x16 (transmit control), 0x1C (interrupt enable), 0x18 (timing word 0) and 0x1A (timing word 1). Read codes are 0xD2 (control), 0xD4 (transmit control), 0xD6 (timing word 0) and 0xD8 (timing word 1). A written value reads back unchanged.
- R3: Reset by `rst_n` or by the one-byte command 0x56 sets the control register to 0x80, whose mode field in bits 7:5 is 4 (initialisation). It zeroes the transmit control, interrupt enable, both timing words and the interrupt flags. `mode_o` always follows control bits 7:5, so a write of 0x20 shows 1 (loopback) and 0x4B shows 2 (listen-only).
- R4: Command 0xE2 returns status with bit 7 = not `tx_busy_i`, bit 4 = `err_warn_i`, bit 3 = `err_passive_i`, bit 2 = `bus_off_i` and bit 1 = not `rx_pending_i`. All other bits are 0, so idle inputs give 0x82.
- R5: Each bit of `err_evt_i` pulsed high sets the matching error-flag bit. Command 0xDC returns the flags and clears them. The 0x56 command leaves the flags untouched.
- R6: Each bit of `int_evt_i` sets the matching interrupt-flag bit. Command 0xDE returns the flags and clears them. An event present in the clearing cycle leaves its bit set.
- R7: `irq_o` is high exactly while the interrupt flags AND the interrupt enable are nonzero. `tx_en_o` is transmit-control bit 7.
- R8: Commands 0xDA, 0xEA and 0xEC return `msg_stat_i`, `rx_err_cnt_i` and `tx_err_cnt_i`, sampled when the command byte completes.
- R9: An unlisted command returns 0x00 and changes no register. Any byte after the second returns 0x00 and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when unselected |
| int_evt_i | input | 8 | Interrupt event pulses, one per flag bit |
| err_evt_i | input | 8 | Error event pulses, one per flag bit |
| rx_pending_i | input | 1 | Receive FIFO holds a frame |
| tx_busy_i | input | 1 | Transmit buffer occupied |
| bus_off_i | input | 1 | Bus-off condition |
| err_passive_i | input | 1 | Error-passive condition |
| err_warn_i | input | 1 | Error-warning condition |
| msg_stat_i | input | 8 | Message status byte |
| tx_err_cnt_i | input | 8 | Transmit error counter |
| rx_err_cnt_i | input | 8 | Receive error counter |
| mode_o | output | 3 | Operating mode field |
| tx_en_o | output | 1 | Transmit enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an interrupt event that lands in the same core cycle as the clearing read. That cycle lies a synchronizer delay after the eighth serial clock edge, so the host cannot see it. The bench holds the event input high across the whole clearing read. The bit then has to survive whatever the alignment, and a second read must still return it. The embedded property that compares the flags after a clearing read with the events of that cycle covers the exact-cycle case. The master-reset command is placed between an error pulse and the error read, which separates the error flags from the registers that reset does clear.

// File: rtl/canspi_pkg.sv
package canspi_pkg;

    localparam int WORD_W = 8;
    localparam int MODE_W = 3;
    localparam int MODE_LSB = WORD_W - MODE_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t OP_MRST    = 8'h56;
    localparam word_t OP_WR_CTL0 = 8'h14;
    localparam word_t OP_WR_CTL1 = 8'h16;
    localparam word_t OP_WR_INTE = 8'h1C;
    localparam word_t OP_WR_TIM0 = 8'h18;
    localparam word_t OP_WR_TIM1 = 8'h1A;
    localparam word_t OP_RD_CTL0 = 8'hD2;
    localparam word_t OP_RD_CTL1 = 8'hD4;
    localparam word_t OP_RD_TIM0 = 8'hD6;
    localparam word_t OP_RD_TIM1 = 8'hD8;
    localparam word_t OP_RD_MSTA = 8'hDA;
    localparam word_t OP_RD_ERRF = 8'hDC;
    localparam word_t OP_RD_INTF = 8'hDE;
    localparam word_t OP_RD_STAT = 8'hE2;
    localparam word_t OP_RD_RCNT = 8'hEA;
    localparam word_t OP_RD_TCNT = 8'hEC;

    localparam word_t CTL0_INIT = 8'h80;

    typedef struct packed {
        word_t ctl0;
        word_t ctl1;
        word_t inte;
        word_t tim0;
        word_t tim1;
        word_t intf;
        word_t errf;
        word_t op;
    } regs_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int              N_SIG   = 3,
    parameter int              STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_i,
    output logic [N_SIG-1:0] sync_o
);

    logic [N_SIG-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import canspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    input  word_t      load_val_i,
    output logic       byte_done_o,
    output word_t      byte_o,
    output logic [1:0] idx_o,
    output logic       miso_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic             sck_prev;
        logic [CNT_W-1:0] bit_cnt;
        logic [1:0]       idx;
        word_t            rx_sr;
        word_t            tx_sr;
    } eng_t;

    eng_t  st_d, st_q;
    logic  rise, fall, done;
    word_t shifted;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        rise          = sck_s & ~st_q.sck_prev;
        fall          = ~sck_s & st_q.sck_prev;
        shifted       = {st_q.rx_sr[WORD_W-2:0], mosi_s};
        done          = 1'b0;
        if (cs_n_s) begin
            st_d.bit_cnt = '0;
            st_d.idx     = '0;
            st_d.tx_sr   = '0;
        end else if (rise) begin
            st_d.rx_sr = shifted;
            if (st_q.bit_cnt == LAST_BIT) begin
                done         = 1'b1;
                st_d.bit_cnt = '0;
                if (st_q.idx != 2'd2) st_d.idx = st_q.idx + 2'd1;
                st_d.tx_sr = (st_q.idx == 2'd0) ? load_val_i : '0;
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end
        end else if (fall && st_q.bit_cnt != '0) begin
            st_d.tx_sr = {st_q.tx_sr[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_done_o = done;
    assign byte_o      = shifted;
    assign idx_o       = st_q.idx;
    assign miso_o      = st_q.tx_sr[WORD_W-1];

    // R1
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso_o);

    // R1
    idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (idx_o == 2'd0));

endmodule

// File: rtl/can_reg_bank.sv
module can_reg_bank
    import canspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done_i,
    input  word_t             byte_i,
    input  logic [1:0]        idx_i,
    input  word_t             int_evt_i,
    input  word_t             err_evt_i,
    input  logic              rx_pending_i,
    input  logic              tx_busy_i,
    input  logic              bus_off_i,
    input  logic              err_passive_i,
    input  logic              err_warn_i,
    input  word_t             msg_stat_i,
    input  word_t             tx_err_cnt_i,
    input  word_t             rx_err_cnt_i,
    output word_t             rd_val_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              tx_en_o,
    output logic              irq_o
);

    regs_t rg_d, rg_q;
    logic  op_done, dat_done, mrst, intf_clr, errf_clr, known_op;
    word_t statf;

    localparam regs_t RST_REGS = '{ctl0: CTL0_INIT, default: '0};

    always_comb begin
        op_done  = byte_done_i && (idx_i == 2'd0);
        dat_done = byte_done_i && (idx_i == 2'd1);
        statf    = {~tx_busy_i, 2'b00, err_warn_i, err_passive_i,
                    bus_off_i, ~rx_pending_i, 1'b0};

        known_op = 1'b1;
        unique case (byte_i)
            OP_RD_CTL0: rd_val_o = rg_q.ctl0;
            OP_RD_CTL1: rd_val_o = rg_q.ctl1;
            OP_RD_TIM0: rd_val_o = rg_q.tim0;
            OP_RD_TIM1: rd_val_o = rg_q.tim1;
            OP_RD_MSTA: rd_val_o = msg_stat_i;
            OP_RD_ERRF: rd_val_o = rg_q.errf;
            OP_RD_INTF: rd_val_o = rg_q.intf;
            OP_RD_STAT: rd_val_o = statf;
            OP_RD_RCNT: rd_val_o = rx_err_cnt_i;
            OP_RD_TCNT: rd_val_o = tx_err_cnt_i;
            OP_MRST, OP_WR_CTL0, OP_WR_CTL1, OP_WR_INTE,
            OP_WR_TIM0, OP_WR_TIM1: rd_val_o = '0;
            default: begin
                rd_val_o = '0;
                known_op = 1'b0;
            end
        endcase

        mrst     = op_done && (byte_i == OP_MRST);
        intf_clr = op_done && (byte_i == OP_RD_INTF);
        errf_clr = op_done && (byte_i == OP_RD_ERRF);

        rg_d      = rg_q;
        rg_d.errf = (errf_clr ? '0 : rg_q.errf) | err_evt_i;
        rg_d.intf = ((intf_clr || mrst) ? '0 : rg_q.intf) | int_evt_i;
        if (op_done) rg_d.op = byte_i;
        if (mrst) begin
            rg_d.ctl0 = CTL0_INIT;
            rg_d.ctl1 = '0;
            rg_d.inte = '0;
            rg_d.tim0 = '0;
            rg_d.tim1 = '0;
        end
        if (dat_done) begin
            case (rg_q.op)
                OP_WR_CTL0: rg_d.ctl0 = byte_i;
                OP_WR_CTL1: rg_d.ctl1 = byte_i;
                OP_WR_INTE: rg_d.inte = byte_i;
                OP_WR_TIM0: rg_d.tim0 = byte_i;
                OP_WR_TIM1: rg_d.tim1 = byte_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= RST_REGS;
        else        rg_q <= rg_d;
    end

    assign mode_o  = rg_q.ctl0[WORD_W-1:MODE_LSB];
    assign tx_en_o = rg_q.ctl1[WORD_W-1];
    assign irq_o   = |(rg_q.intf & rg_q.inte);

    // R3
    mrst_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (rg_q.ctl0 == CTL0_INIT) && (rg_q.inte == '0) && !tx_en_o);

    // R5
    errf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> ((rg_q.errf & $past(rg_q.errf)) == $past(rg_q.errf)));

    // R6
    intf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intf_clr |=> (rg_q.intf == $past(int_evt_i)));

    // R6
    intf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && int_evt_i == '0) |=> $stable(rg_q.intf));

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !known_op) |=> $stable(rg_q.ctl0) && $stable(rg_q.ctl1)
            && $stable(rg_q.inte) && $stable(rg_q.tim0) && $stable(rg_q.tim1));

endmodule

// File: rtl/canspi_frontend.sv
module canspi_frontend
    import canspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] int_evt_i,
    input  logic [7:0] err_evt_i,
    input  logic       rx_pending_i,
    input  logic       tx_busy_i,
    input  logic       bus_off_i,
    input  logic       err_passive_i,
    input  logic       err_warn_i,
    input  logic [7:0] msg_stat_i,
    input  logic [7:0] tx_err_cnt_i,
    input  logic [7:0] rx_err_cnt_i,
    output logic [2:0] mode_o,
    output logic       tx_en_o,
    output logic       irq_o
);

    logic [2:0] pins_s;
    logic       byte_done;
    word_t      byte_w, rd_val;
    logic [1:0] idx;

    spi_in_sync #(
        .N_SIG  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_sck, spi_cs_n, spi_mosi}),
        .sync_o (pins_s)
    );

    spi_byte_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[2]),
        .cs_n_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .load_val_i (rd_val),
        .byte_done_o(byte_done),
        .byte_o     (byte_w),
        .idx_o      (idx),
        .miso_o     (spi_miso)
    );

    can_reg_bank u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_done_i  (byte_done),
        .byte_i       (byte_w),
        .idx_i        (idx),
        .int_evt_i    (int_evt_i),
        .err_evt_i    (err_evt_i),
        .rx_pending_i (rx_pending_i),
        .tx_busy_i    (tx_busy_i),
        .bus_off_i    (bus_off_i),
        .err_passive_i(err_passive_i),
        .err_warn_i   (err_warn_i),
        .msg_stat_i   (msg_stat_i),
        .tx_err_cnt_i (tx_err_cnt_i),
        .rx_err_cnt_i (rx_err_cnt_i),
        .rd_val_o     (rd_val),
        .mode_o       (mode_o),
        .tx_en_o      (tx_en_o),
        .irq_o        (irq_o)
    );

endmodule

// File: tb/canspi_frontend_tb.sv
module canspi_frontend_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [7:0] int_evt = '0, err_evt = '0;
    logic       rx_pend = 1'b0, tx_busy = 1'b0, boff = 1'b0, epass = 1'b0, ewarn = 1'b0;
    logic [7:0] mstat = '0, tcnt = '0, rcnt = '0;
    logic [2:0] mode;
    logic       tx_en, irq;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    canspi_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .int_evt_i(int_evt),
        .err_evt_i(err_evt), .rx_pending_i(rx_pend), .tx_busy_i(tx_busy),
        .bus_off_i(boff), .err_passive_i(epass), .err_warn_i(ewarn),
        .msg_stat_i(mstat), .tx_err_cnt_i(tcnt), .rx_err_cnt_i(rcnt),
        .mode_o(mode), .tx_en_o(tx_en), .irq_o(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_open();
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] op, input logic [7:0] dat);
        logic [7:0] rx;
        cs_open();
        spi_byte(op, rx);
        spi_byte(dat, rx);
        cs_close();
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] rx;
        cs_open();
        spi_byte(op, rx);
        cs_close();
    endtask

    // driver: queue expected byte, run transaction, hand result to monitor
    task automatic rd(input logic [7:0] op, input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs_open();
        spi_byte(op, rx);
        spi_byte(8'h00, rx);
        cs_close();
        got_q.push_back(rx);
    endtask

    task automatic pulse_int(input logic [7:0] v);
        @(negedge clk) int_evt = v;
        @(negedge clk) int_evt = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_err(input logic [7:0] v);
        @(negedge clk) err_evt = v;
        @(negedge clk) err_evt = '0;
        repeat (3) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0)
                chk(got_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 reset state
        chk({5'd0, mode}, 8'd4, "R3 reset mode");
        chk({7'd0, irq}, 8'd0, "R7 reset irq");
        chk({7'd0, tx_en}, 8'd0, "R7 reset tx_en");
        rd(8'hD2, 8'h80, "R3 ctl0 after reset");
        rd(8'hE2, 8'h82, "R4 idle status");

        // R2 / R3 writes and mode
        wr(8'h14, 8'h20);
        chk({5'd0, mode}, 8'd1, "R3 loopback mode");
        rd(8'hD2, 8'h20, "R2 ctl0 readback");
        wr(8'h14, 8'h4B);
        chk({5'd0, mode}, 8'd2, "R3 listen mode");
        rd(8'hD2, 8'h4B, "R2 ctl0 readback 2");
        wr(8'h16, 8'h80);
        chk({7'd0, tx_en}, 8'd1, "R7 tx_en set");
        rd(8'hD4, 8'h80, "R2 ctl1 readback");
        wr(8'h18, 8'hC5);
        rd(8'hD6, 8'hC5, "R2 tim0 readback");
        wr(8'h1A, 8'hA7);
        rd(8'hD8, 8'hA7, "R2 tim1 readback");
        wr(8'h1C, 8'h24);

        // R4 status composition
        boff = 1'b1; rx_pend = 1'b1;
        rd(8'hE2, 8'h84, "R4 busoff rxpending");
        boff = 1'b0; rx_pend = 1'b0; epass = 1'b1; ewarn = 1'b1; tx_busy = 1'b1;
        rd(8'hE2, 8'h1A, "R4 passive warn txbusy");
        epass = 1'b0; ewarn = 1'b0; tx_busy = 1'b0;

        // R8 pass-through values
        mstat = 8'h5A; tcnt = 8'h7F; rcnt = 8'h31;
        rd(8'hDA, 8'h5A, "R8 msg status");
        rd(8'hEC, 8'h7F, "R8 tx counter");
        rd(8'hEA, 8'h31, "R8 rx counter");

        // R6 / R7 interrupt flags
        pulse_int(8'h20);
        chk({7'd0, irq}, 8'd1, "R7 irq on enabled flag");
        rd(8'hDE, 8'h20, "R6 intf read");
        chk({7'd0, irq}, 8'd0, "R7 irq after clear");
        rd(8'hDE, 8'h00, "R6 intf cleared");
        pulse_int(8'h01);
        chk({7'd0, irq}, 8'd0, "R7 masked flag no irq");
        rd(8'hDE, 8'h01, "R6 masked flag stored");

        // R6 event held through clearing read
        @(negedge clk) int_evt = 8'h40;
        repeat (3) @(negedge clk);
        rd(8'hDE, 8'h40, "R6 held event read");
        @(negedge clk) int_evt = 8'h00;
        rd(8'hDE, 8'h40, "R6 event during clear kept");
        rd(8'hDE, 8'h00, "R6 finally cleared");

        // R5 error flags
        pulse_err(8'h11);
        rd(8'hDC, 8'h11, "R5 errf read");
        rd(8'hDC, 8'h00, "R5 errf cleared");

        // R3 / R5 master reset
        pulse_err(8'h06);
        pulse_int(8'h08);
        cmd(8'h56);
        chk({5'd0, mode}, 8'd4, "R3 mrst mode");
        chk({7'd0, tx_en}, 8'd0, "R3 mrst tx_en");
        rd(8'hDC, 8'h06, "R5 errf survives mrst");
        rd(8'hDE, 8'h00, "R3 intf cleared by mrst");
        rd(8'hD2, 8'h80, "R3 ctl0 after mrst");
        rd(8'hD6, 8'h00, "R3 tim0 after mrst");

        // R9 unknown code and extra bytes
        wr(8'h14, 8'h60);
        rd(8'h33, 8'h00, "R9 unknown code returns zero");
        wr(8'h33, 8'hFF);
        rd(8'hD2, 8'h60, "R9 unknown code no change");
        cs_open();
        spi_byte(8'h14, rx);
        spi_byte(8'h20, rx);
        spi_byte(8'hFF, rx);
        cs_close();
        chk(rx, 8'h00, "R9 third byte zero");
        rd(8'hD2, 8'h20, "R9 third byte ignored");

        // R1 aborted byte
        cs_open();
        spi_byte(8'h14, rx);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        cs_close();
        rd(8'hD2, 8'h20, "R1 partial byte discarded");
        rd(8'hD4, 8'h00, "R1 next transaction framed");

        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule